// File: doc/BRIEF.md
# Six-Stage Pipeline Forwarding and Stall Unit

This block makes the data-hazard decisions for an in-order pipeline with the stages IF, ID, EX, MEM1, MEM2 and WB, where data memory access takes two stages. It is purely combinational. Each cycle it looks at the source registers of the instructions in ID and EX. It also looks at the destination, register-write flag and load flag that travel in the ID/EX, EX/MEM1, MEM1/MEM2 and MEM2/WB pipeline registers. From these it produces a select code for each ALU operand multiplexer, and a stall request. The stall request freezes the PC and the IF/ID register and turns the slot entering EX into a bubble.

Load data is ready only at the end of MEM2. It can therefore be forwarded only from the MEM2/WB register. An instruction that uses a loaded register right after the load is held in ID for two cycles. An instruction that uses it two slots after the load is held for one cycle. Results of other instructions can be forwarded from any of the three later pipeline registers. When more than one of those registers holds the same destination, the youngest producer wins.

Top module: `hz6_hazard_unit`

## Requirements
- R1: Operand select codes are 2 bits: 00 takes the register file, 01 takes MEM2/WB, 10 takes MEM1/MEM2 and 11 takes EX/MEM1. With no matching producer, both codes are 00.
- R2: An EX source equal to the destination held in EX/MEM1 of a writing, non-load instruction gives code 11.
- R3: An EX source equal to the destination held in MEM1/MEM2 of a writing, non-load instruction gives code 10.
- R4: An EX source equal to the destination held in MEM2/WB of a writing instruction gives code 01, whether or not that instruction is a load.
- R5: When several registers match, EX/MEM1 wins over MEM1/MEM2, which wins over MEM2/WB.
- R6: Register index 0 never produces a nonzero select code and never causes a stall.
- R7: A load in ID/EX whose destination equals either ID source raises a stall: pc_we=0, ifid_we=0, ex_bubble=1.
- R8: A load in EX/MEM1 whose destination equals either ID source also raises a stall. A load held in MEM1/MEM2 or later never stalls ID.
- R9: A load held in EX/MEM1 or MEM1/MEM2 is never a forwarding source. The select falls to an older matching register, or to 00.
- R10: Without a stall condition, pc_we=1, ifid_we=1 and ex_bubble=0. A non-load producer never stalls ID.
- R11: For the sequence load, dependent subtract, independent add, exactly two bubbles occur. The subtract then takes its loaded operand with code 01.
- R12: The two operands are selected independently, each against its own EX source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source register of the instruction in ID |
| id_rs2 | input | 5 | Second source register of the instruction in ID |
| ex_rs1 | input | 5 | First source register of the instruction in EX |
| ex_rs2 | input | 5 | Second source register of the instruction in EX |
| ex_rd | input | 5 | Destination held in ID/EX |
| ex_ld | input | 1 | Instruction in ID/EX is a load |
| m1_rd | input | 5 | Destination held in EX/MEM1 |
| m1_wr | input | 1 | EX/MEM1 instruction writes the register file |
| m1_ld | input | 1 | EX/MEM1 instruction is a load |
| m2_rd | input | 5 | Destination held in MEM1/MEM2 |
| m2_wr | input | 1 | MEM1/MEM2 instruction writes the register file |
| m2_ld | input | 1 | MEM1/MEM2 instruction is a load |
| wb_rd | input | 5 | Destination held in MEM2/WB |
| wb_wr | input | 1 | MEM2/WB instruction writes the register file |
| fwd_a | output | 2 | Select code for ALU operand A |
| fwd_b | output | 2 | Select code for ALU operand B |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| ex_bubble | output | 1 | Clears the control bits entering EX |

## Verification
Every output is a combinational function of the current pipeline-register contents, so each result is due in the same cycle its inputs are applied. The bench drives inputs just after a rising edge and compares every output at the following falling edge against a behavioural model, one vector per clock. For the instruction sequences, the bench keeps a model of the stage contents that advances on each edge according to the stall output. The bubble count and the operand selects are read in the cycle the watched instruction sits in EX.

// File: rtl/hz6_pkg.sv
package hz6_pkg;

    localparam int RIDX_W    = 5;
    localparam int N_FWD     = 3;   // EX/MEM1, MEM1/MEM2, MEM2/WB
    localparam int N_LDSTALL = 2;   // ID/EX, EX/MEM1
    localparam int SEL_W     = $clog2(N_FWD + 1);

    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [SEL_W-1:0] {
        FWD_RF   = 2'b00,
        FWD_WB   = 2'b01,
        FWD_MEM2 = 2'b10,
        FWD_MEM1 = 2'b11
    } fwd_sel_e;

    typedef struct packed {
        ridx_t rd;
        logic  wr;
        logic  ld;
    } producer_t;

    function automatic logic writes_src(ridx_t src, producer_t p);
        return p.wr && (p.rd == src) && (src != '0);
    endfunction

    function automatic logic load_blocks(ridx_t src, producer_t p);
        return p.ld && (p.rd == src) && (src != '0);
    endfunction

endpackage

// File: rtl/hz6_fwd_pick.sv
module hz6_fwd_pick
    import hz6_pkg::*;
#(
    parameter int N = N_FWD
) (
    input  ridx_t               src,
    input  producer_t [N-1:0]   prod,   // index 0 is the youngest
    output fwd_sel_e            sel
);

    logic [N-1:0] hit;

    // only the oldest stage carries load data that is ready
    for (genvar k = 0; k < N; k++) begin : g_stage
        if (k == N - 1) begin : g_oldest
            assign hit[k] = writes_src(src, prod[k]);
        end else begin : g_early
            assign hit[k] = writes_src(src, prod[k]) && !prod[k].ld;
        end
    end

    always_comb begin
        sel = FWD_RF;
        for (int k = N - 1; k >= 0; k--) begin
            if (hit[k]) sel = fwd_sel_e'(SEL_W'(N - k));
        end
    end

endmodule

// File: rtl/hz6_load_stall.sv
module hz6_load_stall
    import hz6_pkg::*;
#(
    parameter int N = N_LDSTALL
) (
    input  ridx_t             id_src1,
    input  ridx_t             id_src2,
    input  producer_t [N-1:0] prod,
    output logic              stall
);

    logic [N-1:0] blk;

    for (genvar k = 0; k < N; k++) begin : g_stage
        assign blk[k] = load_blocks(id_src1, prod[k]) || load_blocks(id_src2, prod[k]);
    end

    assign stall = |blk;

endmodule

// File: rtl/hz6_hazard_unit.sv
module hz6_hazard_unit
    import hz6_pkg::*;
(
    input  logic [RIDX_W-1:0] id_rs1,
    input  logic [RIDX_W-1:0] id_rs2,
    input  logic [RIDX_W-1:0] ex_rs1,
    input  logic [RIDX_W-1:0] ex_rs2,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic              ex_ld,
    input  logic [RIDX_W-1:0] m1_rd,
    input  logic              m1_wr,
    input  logic              m1_ld,
    input  logic [RIDX_W-1:0] m2_rd,
    input  logic              m2_wr,
    input  logic              m2_ld,
    input  logic [RIDX_W-1:0] wb_rd,
    input  logic              wb_wr,
    output logic [SEL_W-1:0]  fwd_a,
    output logic [SEL_W-1:0]  fwd_b,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              ex_bubble
);

    producer_t [N_FWD-1:0]     fwd_src;
    producer_t [N_LDSTALL-1:0] ld_src;
    ridx_t     [1:0]           ex_src;
    fwd_sel_e  [1:0]           sel;
    logic                      stall;

    // forwarding candidates, youngest first
    assign fwd_src[0] = '{rd: m1_rd, wr: m1_wr, ld: m1_ld};
    assign fwd_src[1] = '{rd: m2_rd, wr: m2_wr, ld: m2_ld};
    assign fwd_src[2] = '{rd: wb_rd, wr: wb_wr, ld: 1'b0};

    // loads whose data is not yet usable by ID's instruction
    assign ld_src[0] = '{rd: ex_rd, wr: ex_ld, ld: ex_ld};
    assign ld_src[1] = '{rd: m1_rd, wr: m1_wr, ld: m1_ld};

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar op = 0; op < 2; op++) begin : g_operand
        hz6_fwd_pick #(.N(N_FWD)) u_pick (
            .src  (ex_src[op]),
            .prod (fwd_src),
            .sel  (sel[op])
        );
    end

    hz6_load_stall #(.N(N_LDSTALL)) u_stall (
        .id_src1 (id_rs1),
        .id_src2 (id_rs2),
        .prod    (ld_src),
        .stall   (stall)
    );

    assign fwd_a     = sel[0];
    assign fwd_b     = sel[1];
    assign pc_we     = !stall;
    assign ifid_we   = !stall;
    assign ex_bubble = stall;

endmodule

// File: rtl/hz6_hazard_unit_chk.sv
module hz6_hazard_unit_chk
    import hz6_pkg::*;
(
    input logic [RIDX_W-1:0] id_rs1,
    input logic [RIDX_W-1:0] id_rs2,
    input logic [RIDX_W-1:0] ex_rs1,
    input logic [RIDX_W-1:0] ex_rs2,
    input logic [RIDX_W-1:0] ex_rd,
    input logic              ex_ld,
    input logic [RIDX_W-1:0] m1_rd,
    input logic              m1_wr,
    input logic              m1_ld,
    input logic [RIDX_W-1:0] m2_rd,
    input logic              m2_wr,
    input logic              m2_ld,
    input logic [RIDX_W-1:0] wb_rd,
    input logic              wb_wr,
    input logic [SEL_W-1:0]  fwd_a,
    input logic [SEL_W-1:0]  fwd_b,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              ex_bubble
);

    logic known;
    assign known = !$isunknown({id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, ex_ld,
                                m1_rd, m1_wr, m1_ld, m2_rd, m2_wr, m2_ld,
                                wb_rd, wb_wr, fwd_a, fwd_b, pc_we, ifid_we, ex_bubble});

    always_comb begin
        if (known) begin
            if (ex_rs1 == '0)
                assert_zero_src_a_R6: assert (fwd_a == 2'b00);
            if (ex_rs2 == '0)
                assert_zero_src_b_R6: assert (fwd_b == 2'b00);
            if (fwd_a == 2'b11)
                assert_mem1_src_R9: assert (m1_wr && !m1_ld && m1_rd == ex_rs1);
            if (fwd_a == 2'b10)
                assert_mem2_src_R3: assert (m2_wr && !m2_ld && m2_rd == ex_rs1);
            if (fwd_a == 2'b01)
                assert_wb_src_R4: assert (wb_wr && wb_rd == ex_rs1);
            if (ex_ld && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2))
                assert_idex_load_stall_R7: assert (ex_bubble && !pc_we && !ifid_we);
            if (m1_ld && m1_rd != '0 && (m1_rd == id_rs1 || m1_rd == id_rs2))
                assert_mem1_load_stall_R8: assert (ex_bubble && !pc_we && !ifid_we);
            if (!ex_ld && !m1_ld)
                assert_no_load_no_stall_R10: assert (pc_we && ifid_we && !ex_bubble);
        end
    end

endmodule

bind hz6_hazard_unit hz6_hazard_unit_chk chk_i (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_ld(ex_ld), .m1_rd(m1_rd), .m1_wr(m1_wr), .m1_ld(m1_ld),
    .m2_rd(m2_rd), .m2_wr(m2_wr), .m2_ld(m2_ld), .wb_rd(wb_rd), .wb_wr(wb_wr),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we), .ex_bubble(ex_bubble)
);

// File: tb/hz6_hazard_unit_tb_top.sv
module hz6_hazard_unit_tb_top;
    import hz6_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [RIDX_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, m1_rd, m2_rd, wb_rd;
    logic ex_ld, m1_wr, m1_ld, m2_wr, m2_ld, wb_wr;
    logic [SEL_W-1:0] fwd_a, fwd_b;
    logic pc_we, ifid_we, ex_bubble;

    int vectors = 0;
    int miscompares = 0;

    hz6_hazard_unit dut_i (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_ld(ex_ld), .m1_rd(m1_rd), .m1_wr(m1_wr), .m1_ld(m1_ld),
        .m2_rd(m2_rd), .m2_wr(m2_wr), .m2_ld(m2_ld), .wb_rd(wb_rd), .wb_wr(wb_wr),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we), .ex_bubble(ex_bubble)
    );

    // behavioural model of the requirements
    function automatic int model_fwd(int src);
        if (src == 0) return 0;
        if (m1_wr && !m1_ld && int'(m1_rd) == src) return 3;
        if (m2_wr && !m2_ld && int'(m2_rd) == src) return 2;
        if (wb_wr && int'(wb_rd) == src) return 1;
        return 0;
    endfunction

    function automatic bit model_stall();
        int a = int'(id_rs1);
        int b = int'(id_rs2);
        bit s = 0;
        if (ex_ld && ex_rd != 0 && (int'(ex_rd) == a || int'(ex_rd) == b)) s = 1;
        if (m1_ld && m1_rd != 0 && (int'(m1_rd) == a || int'(m1_rd) == b)) s = 1;
        return s;
    endfunction

    task automatic compare_all(string tag);
        int ea = model_fwd(int'(ex_rs1));
        int eb = model_fwd(int'(ex_rs2));
        bit es = model_stall();
        vectors++;
        if (fwd_a !== 2'(ea) || fwd_b !== 2'(eb) || ex_bubble !== es
            || pc_we !== !es || ifid_we !== !es) begin
            miscompares++;
            $display("FAIL %s: actual a=%0d b=%0d pc_we=%0b ifid_we=%0b bubble=%0b expected a=%0d b=%0d pc_we=%0b ifid_we=%0b bubble=%0b",
                     tag, fwd_a, fwd_b, pc_we, ifid_we, ex_bubble, ea, eb, !es, !es, es);
        end
    endtask

    task automatic drive(int i1, int i2, int e1, int e2, int erd, int eld,
                         int r1, int w1, int l1, int r2, int w2, int l2, int r3, int w3);
        id_rs1 = RIDX_W'(i1); id_rs2 = RIDX_W'(i2);
        ex_rs1 = RIDX_W'(e1); ex_rs2 = RIDX_W'(e2);
        ex_rd  = RIDX_W'(erd); ex_ld = eld[0];
        m1_rd  = RIDX_W'(r1); m1_wr = w1[0]; m1_ld = l1[0];
        m2_rd  = RIDX_W'(r2); m2_wr = w2[0]; m2_ld = l2[0];
        wb_rd  = RIDX_W'(r3); wb_wr = w3[0];
    endtask

    task automatic vec(string tag, int i1, int i2, int e1, int e2, int erd, int eld,
                       int r1, int w1, int l1, int r2, int w2, int l2, int r3, int w3);
        @(posedge clk);
        #1 drive(i1, i2, e1, e2, erd, eld, r1, w1, l1, r2, w2, l2, r3, w3);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic check_val(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // stage model: 0=ID 1=ID/EX 2=EX/MEM1 3=MEM1/MEM2 4=MEM2/WB
    task automatic run_prog(string tag, input int p1[3], input int p2[3], input int pd[3],
                            input int pl[3], int watch, int exp_bub, int exp_a, int exp_b);
        int sv[5], s1[5], s2[5], sd[5], sl[5], si[5];
        int pc = 0;
        int bub = 0;
        bit seen = 0;
        for (int k = 0; k < 5; k++) begin
            sv[k] = 0; s1[k] = 0; s2[k] = 0; sd[k] = 0; sl[k] = 0; si[k] = -1;
        end
        for (int cyc = 0; cyc < 12; cyc++) begin
            @(posedge clk);
            #1 drive(sv[0] ? s1[0] : 0, sv[0] ? s2[0] : 0,
                     sv[1] ? s1[1] : 0, sv[1] ? s2[1] : 0, sv[1] ? sd[1] : 0, sv[1] ? sl[1] : 0,
                     sd[2], sv[2], sl[2], sd[3], sv[3], sl[3], sd[4], sv[4]);
            @(negedge clk);
            compare_all(tag);
            if (sv[1] && si[1] == watch) begin
                seen = 1;
                check_val({tag, " operand A select of watched op"}, int'(fwd_a), exp_a);
                check_val({tag, " operand B select of watched op"}, int'(fwd_b), exp_b);
            end
            if (ex_bubble === 1'b1) bub++;
            for (int k = 4; k >= 2; k--) begin
                sv[k] = sv[k-1]; s1[k] = s1[k-1]; s2[k] = s2[k-1];
                sd[k] = sd[k-1]; sl[k] = sl[k-1]; si[k] = si[k-1];
            end
            if (ex_bubble === 1'b1) begin
                sv[1] = 0; s1[1] = 0; s2[1] = 0; sd[1] = 0; sl[1] = 0; si[1] = -1;
            end else begin
                sv[1] = sv[0]; s1[1] = s1[0]; s2[1] = s2[0];
                sd[1] = sd[0]; sl[1] = sl[0]; si[1] = si[0];
                if (pc < 3) begin
                    sv[0] = 1; s1[0] = p1[pc]; s2[0] = p2[pc];
                    sd[0] = pd[pc]; sl[0] = pl[pc]; si[0] = pc;
                    pc++;
                end else begin
                    sv[0] = 0; s1[0] = 0; s2[0] = 0; sd[0] = 0; sl[0] = 0; si[0] = -1;
                end
            end
        end
        check_val({tag, " bubble count"}, bub, exp_bub);
        check_val({tag, " watched op reached EX"}, int'(seen), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: idle state, all codes 00, enables high
        vec("R1 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        vec("R1 no match", 1, 2, 3, 4, 5, 0, 6, 1, 0, 7, 1, 0, 8, 1);
        // R2: EX/MEM1 non-load producer
        vec("R2 mem1 fwd", 0, 0, 3, 0, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0);
        // R3: MEM1/MEM2 non-load producer on operand B
        vec("R3 mem2 fwd", 0, 0, 0, 4, 0, 0, 0, 0, 0, 4, 1, 0, 0, 0);
        // R4: MEM2/WB producer, load and non-load
        vec("R4 wb fwd", 0, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5, 1);
        vec("R4 wb no write", 0, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0);
        // R5: priority youngest first
        vec("R5 all match", 0, 0, 7, 7, 0, 0, 7, 1, 0, 7, 1, 0, 7, 1);
        vec("R5 mem2 over wb", 0, 0, 7, 0, 0, 0, 7, 0, 0, 7, 1, 0, 7, 1);
        // R6: register zero
        vec("R6 zero fwd", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1);
        vec("R6 zero stall", 0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0, 0);
        // R7: load in ID/EX
        vec("R7 idex load rs2", 3, 8, 0, 0, 8, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        vec("R7 idex load rs1", 8, 3, 0, 0, 8, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: load in EX/MEM1 stalls, load in MEM1/MEM2 does not
        vec("R8 mem1 load", 9, 0, 0, 0, 0, 0, 9, 1, 1, 0, 0, 0, 0, 0);
        vec("R8 mem2 load no stall", 9, 0, 0, 0, 0, 0, 0, 0, 0, 9, 1, 1, 0, 0);
        // R9: loads not forwarded early
        vec("R9 mem1 load to wb", 0, 0, 10, 0, 0, 0, 10, 1, 1, 0, 0, 0, 10, 1);
        vec("R9 mem2 load to rf", 0, 0, 0, 11, 0, 0, 0, 0, 0, 11, 1, 1, 0, 0);
        // R10: non-load producers never stall
        vec("R10 alu in idex", 6, 6, 0, 0, 6, 0, 6, 1, 0, 6, 1, 0, 6, 1);
        // R12: operands independent
        vec("R12 split", 0, 0, 12, 13, 0, 0, 12, 1, 0, 0, 0, 0, 13, 1);
        vec("R12 swapped", 0, 0, 13, 12, 0, 0, 12, 1, 0, 13, 1, 0, 0, 0);

        for (int n = 0; n < 400; n++) begin
            int l0 = $urandom_range(0, 1);
            int l1 = $urandom_range(0, 1);
            int l2 = $urandom_range(0, 1);
            vec("RND", $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3), l0,
                $urandom_range(0, 3), l1 | $urandom_range(0, 1), l1,
                $urandom_range(0, 3), l2 | $urandom_range(0, 1), l2,
                $urandom_range(0, 3), $urandom_range(0, 1));
        end

        // R11: load r12 <- [r10]; sub r14 <- r12 - r11; add r10 <- r11 + r13
        run_prog("R11 load-use", '{10, 12, 11}, '{0, 11, 13}, '{12, 14, 10}, '{1, 0, 0},
                 1, 2, 1, 0);
        // R8: use two slots after the load costs one bubble
        run_prog("R8 load-gap-use", '{10, 11, 12}, '{0, 13, 11}, '{12, 10, 14}, '{1, 0, 0},
                 2, 1, 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule